// File: doc/BRIEF.md
# XNOR-feedback LFSR sequence counter

This block is a shift-register counter whose next state comes from a linear function of a few of its own bits. On every enabled clock the register moves one place toward its most significant bit, and a new bit 0 is formed as the XNOR of the chosen tap bits. The result steps through a long fixed sequence of states. It costs one register and a small XOR tree, with no carry chain, so it suits pseudo-random sources and counters whose values do not need to be in numeric order, such as FIFO pointers.

Because the feedback is XNOR rather than XOR, all-zeros is a normal member of the sequence and is the reset value. All-ones is the single state that would map to itself. The block raises a flag while it holds that state, and an enabled step from it returns the register to zero. The register length and the tap set are compile-time parameters. The defaults are a 15-bit register with taps on bits 14 and 0, which gives the maximal period of 32767. A synchronous load input places any value in the register.

Top module: `lfsr_xnor_counter`

## Requirements
- R1: When `rst` is high at a clock edge, `state` becomes all zeros after that edge.
- R2: When `rst`, `load` and `en` are all low at a clock edge, `state` keeps its value.
- R3: When `en` is high and `rst` and `load` are low, and `state` is not all ones, the next state is `state` shifted left by one bit. The new bit 0 is the XNOR of the bits selected by `TAP_MASK`, where bit i of the mask selects state bit i. With the defaults, the new bit 0 is the XNOR of bit 14 and bit 0.
- R4: When `load` is high and `rst` is low, `state` takes `load_value` at the next edge, whatever the level of `en`.
- R5: `rst` has priority over `load`, and `load` has priority over counting.
- R6: `lockup` is high in exactly those cycles in which `state` is all ones.
- R7: An enabled step from the all-ones state, with no reset and no load, gives all zeros.
- R8: Starting from reset with `en` held high, the default instance first returns to all zeros after exactly 32767 steps, and `lockup` stays low in every cycle of that run.
- R9: A 4-bit instance with mask 4'b1100 first returns to zero after 15 steps. A 5-bit instance with mask 5'b10100 first returns to zero after 31 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| en | input | 1 | Advances the sequence by one step per clock |
| load | input | 1 | Synchronous load of `load_value` |
| load_value | input | WIDTH | Value placed in the register on a load |
| state | output | WIDTH | Current register contents |
| lockup | output | 1 | High while `state` is all ones |

## Verification
Any error in the register shows on `state` at the edge right after it occurs, because `state` is the register itself. A wrong feedback bit appears in bit 0 at once. After that the wrong value spreads up through the bits, and the whole sequence diverges from the expected one. A mistake in the lock-up escape shows in one of two ways: `state` stays at all ones, or `lockup` stays high, during the step after an all-ones load. A tap set that is not maximal first shows up as a wrong return-to-zero count at the end of the long run.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Default configuration: 15-bit register, taps on bits 14 and 0
    localparam int unsigned DEF_WIDTH = 15;
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 15'h4001;

    // Action taken at the next clock edge, in priority order
    typedef enum logic [2:0] {
        ACT_CLEAR  = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_ESCAPE = 3'd2,
        ACT_SHIFT  = 3'd3,
        ACT_HOLD   = 3'd4
    } lfsr_act_e;

    function automatic lfsr_act_e pick_action(input logic rst_i, input logic load_i,
                                              input logic en_i, input logic stuck_i);
        if (rst_i)       return ACT_CLEAR;
        else if (load_i) return ACT_LOAD;
        else if (!en_i)  return ACT_HOLD;
        else if (stuck_i) return ACT_ESCAPE;
        else             return ACT_SHIFT;
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
    parameter int unsigned WIDTH = lfsr_pkg::DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK = lfsr_pkg::DEF_TAPS
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] shifted
);
    logic [WIDTH-1:0] tapped;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_tap
            if (TAP_MASK[i]) begin : g_on
                assign tapped[i] = cur[i];
            end else begin : g_off
                assign tapped[i] = 1'b0;
            end
        end
    endgenerate

    assign shifted = {cur[WIDTH-2:0], ~(^tapped)};
endmodule

// File: rtl/lfsr_lockup_detect.sv
module lfsr_lockup_detect #(
    parameter int unsigned WIDTH = lfsr_pkg::DEF_WIDTH
) (
    input  logic [WIDTH-1:0] cur,
    output logic             stuck
);
    assign stuck = &cur;
endmodule

// File: rtl/lfsr_xnor_counter.sv
module lfsr_xnor_counter
    import lfsr_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK = DEF_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] load_value,
    output logic [WIDTH-1:0] state,
    output logic             lockup
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] shifted;
    logic             stuck;
    lfsr_act_e        act;

    lfsr_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
        .cur     (shift_q),
        .shifted (shifted)
    );

    lfsr_lockup_detect #(.WIDTH(WIDTH)) u_lock (
        .cur   (shift_q),
        .stuck (stuck)
    );

    assign act = pick_action(rst, load, en, stuck);

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR:  shift_q <= '0;
            ACT_LOAD:   shift_q <= load_value;
            ACT_ESCAPE: shift_q <= '0;
            ACT_SHIFT:  shift_q <= shifted;
            default:    shift_q <= shift_q;
        endcase
    end

    assign state  = shift_q;
    assign lockup = stuck;

    // Assertions
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (state == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!load && !en) |=> $stable(state));

    assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && en && state != ALL_ONES) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == $past(load_value)));

    assert_flag_R6: assert property (@(posedge clk) disable iff (rst)
        lockup |-> (state == ALL_ONES));

    assert_escape_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && en && lockup) |=> (state == '0 && !lockup));

endmodule

// File: tb/tb_lfsr_xnor_counter.sv
module tb_lfsr_xnor_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [14:0] load_value = '0;
    logic [14:0] state;
    logic        lockup;
    logic [3:0]  state4;
    logic        lockup4;
    logic [4:0]  state5;
    logic        lockup5;

    int checks = 0;
    int fails = 0;
    logic [14:0] model = '0;

    always #2 clk = ~clk;

    lfsr_xnor_counter dut (
        .clk(clk), .rst(rst), .en(en), .load(load), .load_value(load_value),
        .state(state), .lockup(lockup)
    );

    lfsr_xnor_counter #(.WIDTH(4), .TAP_MASK(4'b1100)) dut4 (
        .clk(clk), .rst(rst), .en(en), .load(1'b0), .load_value(4'h0),
        .state(state4), .lockup(lockup4)
    );

    lfsr_xnor_counter #(.WIDTH(5), .TAP_MASK(5'b10100)) dut5 (
        .clk(clk), .rst(rst), .en(en), .load(1'b0), .load_value(5'h00),
        .state(state5), .lockup(lockup5)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: update the reference model from the inputs, then compare.
    task automatic step(input string req);
        @(posedge clk);
        if (rst)
            model = '0;
        else if (load)
            model = load_value;
        else if (en) begin
            if (model == 15'h7FFF)
                model = '0;
            else
                model = {model[13:0], ~(model[14] ^ model[0])};
        end
        @(negedge clk);
        check(state == model, req, state, model);
        check(lockup == (model == 15'h7FFF), "R6", lockup, model == 15'h7FFF);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int z15;
        int z4;
        int z5;
        bit seen_lock;

        // Reset to zero
        @(negedge clk);
        step("R1");
        step("R1");
        check(state == 15'h0, "R1", state, 0);

        // Counting from zero: 0 -> 1 -> 2 -> 5 -> A
        rst = 1'b0;
        en = 1'b1;
        step("R3");
        check(state == 15'h1, "R3", state, 1);
        step("R3");
        check(state == 15'h2, "R3", state, 2);
        step("R3");
        check(state == 15'h5, "R3", state, 5);
        step("R3");
        check(state == 15'hA, "R3", state, 'hA);
        for (int i = 0; i < 40; i++) step("R3");

        // Hold while disabled
        en = 1'b0;
        for (int i = 0; i < 3; i++) step("R2");

        // Load all ones while enabled; the flag rises
        en = 1'b1;
        load = 1'b1;
        load_value = 15'h7FFF;
        step("R4");
        check(lockup == 1'b1, "R6", lockup, 1);
        load = 1'b0;
        en = 1'b0;
        step("R2");
        check(state == 15'h7FFF, "R2", state, 'h7FFF);

        // Escape from the lock-up state
        en = 1'b1;
        step("R7");
        check(state == 15'h0 && !lockup, "R7", state, 0);

        // Load while disabled
        en = 1'b0;
        load = 1'b1;
        load_value = 15'h1234;
        step("R4");
        check(state == 15'h1234, "R4", state, 'h1234);

        // Load beats counting
        en = 1'b1;
        load_value = 15'h0F0F;
        step("R5");
        check(state == 15'h0F0F, "R5", state, 'h0F0F);

        // Reset beats load
        rst = 1'b1;
        load_value = 15'h5555;
        step("R5");
        check(state == 15'h0, "R5", state, 0);
        load = 1'b0;
        step("R1");

        // Full-period run from zero
        rst = 1'b0;
        en = 1'b1;
        z15 = 0;
        z4 = 0;
        z5 = 0;
        seen_lock = 1'b0;
        for (int i = 1; i <= 33000 && z15 == 0; i++) begin
            step("R8");
            if (lockup) seen_lock = 1'b1;
            if (state == 15'h0 && z15 == 0) z15 = i;
            if (state4 == 4'h0 && z4 == 0) z4 = i;
            if (state5 == 5'h0 && z5 == 0) z5 = i;
        end
        check(z15 == 32767, "R8", z15, 32767);
        check(!seen_lock, "R8", seen_lock, 0);
        check(z4 == 15, "R9", z4, 15);
        check(z5 == 31, "R9", z5, 31);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule